// File: doc/BRIEF.md
# Byte-Stream SPI Master Controller

This block is a register-mapped serial peripheral interface master. Software fills an 8-entry transmit queue through a small synchronous register bus. It sets the clock polarity, clock phase, frame width and a power-of-two clock divisor in one configuration word. It then writes a go bit to launch a burst. The controller drives the chip select low and shifts the queued bytes out MSB first. Every byte clocked in from the slave is placed in an 8-entry receive queue, which software drains in arrival order.

A burst runs back to back until the transmit queue is empty at a frame boundary. It then releases the chip select. An external chip-select input watches for a second master. If that input goes low while this block is the enabled master, a mode-fail flag is latched, the global enable is dropped and any burst is cut off. Four status conditions can drive a single interrupt line. Their mask is edited through separate set-on-one and clear-on-one addresses.

The register word at index 0 (configuration) has these fields:
- bit 0: polarity
- bit 1: phase
- bits 3:2: width code
- bits 6:4: divisor code
- bit 7: master select
- bit 8: go

The other register indices are:
- 1: enable, bit 0
- 2: transmit write
- 3: receive read
- 4: status
- 5: mask set
- 6: mask clear

Top module: `spim_ctrl`

## Requirements
- R1: With divisor code c in configuration bits 6:4, every SCLK period lasts 2^(c+1) clock cycles, so code 0 gives 2 and code 7 gives 256.
- R2: Configuration bit 0 (polarity) sets the SCLK idle level. Bit 1 (phase) selects the sampling edge. With phase 0, MOSI is valid before the leading edge, is sampled on it and changes on the trailing edge. With phase 1, MOSI changes on the leading edge and is sampled on the trailing edge. Bits go out and come in MSB first.
- R3: Writing a byte to index 2 does not start shifting. A burst begins only after a 1 is written to configuration bit 8. That bit reads back 1 while the request is pending and 0 once the burst has started. Writing 0 to it leaves a pending request in place.
- R4: Every byte shifted out places one received byte into the receive queue. Reads of index 3 return those bytes in order. A read of index 3 with the queue empty returns 0 and changes nothing.
- R5: Width code 01 in configuration bits 3:2 selects 16-bit frames made of two queued bytes, high byte first. If the transmit queue runs dry after a high byte, the low byte is sent as 0x00 and both received bytes are kept. Any other code selects 8-bit frames.
- R6: When a burst starts, chip select falls while SCLK sits at its idle level. It stays low across back-to-back bytes of one burst. It rises half an SCLK period after the last frame ends with the transmit queue empty. While chip select is high, SCLK equals the polarity bit.
- R7: Each queue holds 8 bytes. A transmit write to a full queue is dropped.
- R8: Status at index 4 has these bits: bit 0 mode fail, bit 1 transmit full, bit 2 transmit not full, bit 3 receive not empty. The irq output is the OR of the status bits ANDed with the mask.
- R9: Writing ones to index 5 sets the matching mask bits. Writing ones to index 6 clears them. Both indices read back the mask.
- R10: While the enable bit (index 1, bit 0) or the master-select bit (configuration bit 7) is 0, no burst starts and a go request stays pending. Setting the bit later starts the pending burst.
- R11: If the chip-select input is low while enable and master select are both 1, these things happen: status bit 0 is latched, the enable bit is cleared, and any burst is aborted with chip select driven high. Writing 1 to status bit 0 clears the flag. With master select 0, the input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | BUS_W | Write data |
| reg_rdata | output | BUS_W | Read data (combinational) |
| irq | output | 1 | Masked status interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| miso | input | 1 | Serial data from slave |
| cs_n | output | 1 | Active-low chip select |
| ss_in_n | input | 1 | Chip-select input watched for another master |

## Verification
The bench sweeps all eight divisor codes and measures the SCLK period. A divisor decode that is off by one would show up as a period that is halved or doubled.

It runs all four polarity and phase modes against a slave model and compares every shifted and received byte. A design that sampled on the wrong edge would lose the first or last bit of each byte. It also catches a chip select that drops between bytes, or an SCLK that moves before chip select settles.

Odd byte counts in 16-bit mode check that the missing low byte is padded. A full transmit queue of nine writes checks that the ninth is dropped rather than overwriting a queued entry. The bench also confirms that a go request survives a disabled controller, and that a mode fail in the middle of a burst releases chip select and drops the enable.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 3;
  localparam int NIRQ   = 4;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_EN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_TXD  = 3'd2;
  localparam logic [ADDR_W-1:0] A_RXD  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] A_MSET = 3'd5;
  localparam logic [ADDR_W-1:0] A_MCLR = 3'd6;

  localparam int CFG_CPOL = 0;
  localparam int CFG_CPHA = 1;
  localparam int CFG_WID  = 2;
  localparam int CFG_DIV  = 4;
  localparam int CFG_MSEL = 7;
  localparam int CFG_GO   = 8;
  localparam int CFG_W    = 9;

  localparam int IRQ_MF   = 0;
  localparam int IRQ_TXF  = 1;
  localparam int IRQ_TXNF = 2;
  localparam int IRQ_RXNE = 3;

  typedef enum logic [1:0] {ENG_IDLE, ENG_RUN, ENG_TAIL} eng_state_t;
endpackage

// File: rtl/spim_rst_sync.sv
module spim_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem[rd_q];

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (do_push) wr_n = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_n = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop)      cnt_n = cnt_q + 1'b1;
    else if (!do_push && do_pop) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata;
  end

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  a_r7_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt_q == $past(cnt_q)));
  a_r4_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_ok,
  input  logic              start_req,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              wide,
  input  logic [DIV_W-1:0]  div_code,
  input  logic              tx_empty,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              miso,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              started,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n
);
  localparam int HC_W   = (1 << DIV_W) - 1;
  localparam int EDGES  = 2 * BYTE_W;
  localparam int EDGE_W = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  eng_state_t        st_q, st_n;
  logic [HC_W-1:0]   hcnt_q, hcnt_n, limit;
  logic [EDGE_W-1:0] edge_q, edge_n;
  logic [BYTE_W-1:0] tx_sh_q, tx_sh_n, rx_sh_q, rx_sh_n, next_byte;
  logic              sclk_q, sclk_n, out_q, out_n, cs_q, cs_n_n, hi_q, hi_n;
  logic              tick, lead, sample;

  assign limit = HC_W'((8'd1 << div_code) - 8'd1);
  assign tick  = (hcnt_q == limit);
  assign lead  = ~edge_q[0];
  assign sample = lead ^ cpha;
  assign next_byte = tx_empty ? '0 : tx_byte;

  always_comb begin
    st_n    = st_q;
    hcnt_n  = hcnt_q;
    edge_n  = edge_q;
    tx_sh_n = tx_sh_q;
    rx_sh_n = rx_sh_q;
    sclk_n  = sclk_q;
    out_n   = out_q;
    cs_n_n  = cs_q;
    hi_n    = hi_q;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    started = 1'b0;
    case (st_q)
      ENG_IDLE: begin
        if (run_ok && start_req && !tx_empty) begin
          tx_pop  = 1'b1;
          started = 1'b1;
          tx_sh_n = tx_byte;
          out_n   = cpha ? 1'b0 : tx_byte[BYTE_W-1];
          cs_n_n  = 1'b0;
          hcnt_n  = '0;
          edge_n  = '0;
          sclk_n  = 1'b0;
          hi_n    = 1'b1;
          st_n    = ENG_RUN;
        end
      end
      ENG_RUN: begin
        if (!run_ok) begin
          st_n = ENG_IDLE; cs_n_n = 1'b1; sclk_n = 1'b0;
        end else if (!tick) begin
          hcnt_n = hcnt_q + 1'b1;
        end else begin
          hcnt_n = '0;
          sclk_n = ~sclk_q;
          edge_n = edge_q + 1'b1;
          if (sample) rx_sh_n = {rx_sh_q[BYTE_W-2:0], miso};
          if (edge_q == LAST_EDGE) begin
            rx_push = 1'b1;
            if ((wide && hi_q) || !tx_empty) begin
              tx_pop  = ~tx_empty;
              tx_sh_n = next_byte;
              if (!cpha) out_n = next_byte[BYTE_W-1];
              hi_n    = wide ? ~hi_q : 1'b1;
            end else begin
              st_n = ENG_TAIL;
            end
          end else if (!sample) begin
            out_n   = cpha ? tx_sh_q[BYTE_W-1] : tx_sh_q[BYTE_W-2];
            tx_sh_n = tx_sh_q << 1;
          end
        end
      end
      ENG_TAIL: begin
        if (!run_ok) begin
          st_n = ENG_IDLE; cs_n_n = 1'b1; sclk_n = 1'b0;
        end else if (tick) begin
          st_n = ENG_IDLE; cs_n_n = 1'b1;
        end else begin
          hcnt_n = hcnt_q + 1'b1;
        end
      end
      default: st_n = ENG_IDLE;
    endcase
    rx_byte = rx_sh_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ENG_IDLE;
      hcnt_q  <= '0;
      edge_q  <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      sclk_q  <= 1'b0;
      out_q   <= 1'b0;
      cs_q    <= 1'b1;
      hi_q    <= 1'b1;
    end else begin
      st_q    <= st_n;
      hcnt_q  <= hcnt_n;
      edge_q  <= edge_n;
      tx_sh_q <= tx_sh_n;
      rx_sh_q <= rx_sh_n;
      sclk_q  <= sclk_n;
      out_q   <= out_n;
      cs_q    <= cs_n_n;
      hi_q    <= hi_n;
    end
  end

  assign sclk = sclk_q ^ cpol;
  assign mosi = out_q;
  assign cs_n = cs_q;

  a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> (sclk == cpol));
  a_r4_push_inside_burst: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !cs_q);
  a_r11_abort_releases_cs: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q != ENG_IDLE) && !run_ok) |=> cs_q);
  a_r6_cs_fall_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |-> (sclk == cpol));
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int BUS_W      = 16,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n,
  input  logic              ss_in_n
);
  logic              rst_i;
  logic              cpol_q, cpol_n, cpha_q, cpha_n, msel_q, msel_n;
  logic              go_q, go_n, en_q, en_n, mf_q, mf_n;
  logic [1:0]        wid_q, wid_n;
  logic [DIV_W-1:0]  div_q, div_n;
  logic [NIRQ-1:0]   mask_q, mask_n, stat;
  logic              wr_cfg, wr_en, wr_tx, wr_stat, wr_set, wr_clr, rd_rx, mf_event;
  logic              tx_pop, tx_empty, tx_full, rx_push, rx_empty, rx_full, eng_started;
  logic [BYTE_W-1:0] tx_head, rx_head, rx_byte;
  wire               unused_bits = ^{reg_wdata[BUS_W-1:CFG_W], rx_full};

  spim_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_i));

  assign wr_cfg  = reg_sel & reg_wr & (reg_addr == A_CFG);
  assign wr_en   = reg_sel & reg_wr & (reg_addr == A_EN);
  assign wr_tx   = reg_sel & reg_wr & (reg_addr == A_TXD);
  assign wr_stat = reg_sel & reg_wr & (reg_addr == A_STAT);
  assign wr_set  = reg_sel & reg_wr & (reg_addr == A_MSET);
  assign wr_clr  = reg_sel & reg_wr & (reg_addr == A_MCLR);
  assign rd_rx   = reg_sel & ~reg_wr & (reg_addr == A_RXD);
  assign mf_event = en_q & msel_q & ~ss_in_n;

  always_comb begin
    cpol_n = cpol_q; cpha_n = cpha_q; wid_n = wid_q; div_n = div_q; msel_n = msel_q;
    if (wr_cfg) begin
      cpol_n = reg_wdata[CFG_CPOL];
      cpha_n = reg_wdata[CFG_CPHA];
      wid_n  = reg_wdata[CFG_WID +: 2];
      div_n  = reg_wdata[CFG_DIV +: DIV_W];
      msel_n = reg_wdata[CFG_MSEL];
    end
    go_n   = (go_q & ~eng_started) | (wr_cfg & reg_wdata[CFG_GO]);
    en_n   = mf_event ? 1'b0 : (wr_en ? reg_wdata[0] : en_q);
    mf_n   = mf_event | (mf_q & ~(wr_stat & reg_wdata[IRQ_MF]));
    mask_n = (mask_q | (wr_set ? reg_wdata[NIRQ-1:0] : '0))
           & ~(wr_clr ? reg_wdata[NIRQ-1:0] : '0);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cpol_q <= 1'b0; cpha_q <= 1'b0; wid_q <= '0; div_q <= '0; msel_q <= 1'b0;
      go_q   <= 1'b0; en_q   <= 1'b0; mf_q  <= 1'b0; mask_q <= '0;
    end else begin
      cpol_q <= cpol_n; cpha_q <= cpha_n; wid_q <= wid_n; div_q <= div_n; msel_q <= msel_n;
      go_q   <= go_n;   en_q   <= en_n;   mf_q  <= mf_n;  mask_q <= mask_n;
    end
  end

  spim_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_i), .push(wr_tx), .wdata(reg_wdata[BYTE_W-1:0]),
    .pop(tx_pop), .rdata(tx_head), .empty(tx_empty), .full(tx_full));

  spim_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_i), .push(rx_push), .wdata(rx_byte),
    .pop(rd_rx), .rdata(rx_head), .empty(rx_empty), .full(rx_full));

  spim_engine u_eng (
    .clk(clk), .rst_n(rst_i), .run_ok(en_q & msel_q), .start_req(go_q),
    .cpol(cpol_q), .cpha(cpha_q), .wide(wid_q == 2'b01), .div_code(div_q),
    .tx_empty(tx_empty), .tx_byte(tx_head), .miso(miso),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte), .started(eng_started),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n));

  always_comb begin
    stat            = '0;
    stat[IRQ_MF]    = mf_q;
    stat[IRQ_TXF]   = tx_full;
    stat[IRQ_TXNF]  = ~tx_full;
    stat[IRQ_RXNE]  = ~rx_empty;
  end

  assign irq = |(stat & mask_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CFG:  reg_rdata[CFG_W-1:0] = {go_q, msel_q, div_q, wid_q, cpha_q, cpol_q};
      A_EN:   reg_rdata[0] = en_q;
      A_RXD:  reg_rdata[BYTE_W-1:0] = rx_empty ? '0 : rx_head;
      A_STAT: reg_rdata[NIRQ-1:0] = stat;
      A_MSET, A_MCLR: reg_rdata[NIRQ-1:0] = mask_q;
      default: reg_rdata = '0;
    endcase
  end

  a_r9_set_ones: assert property (@(posedge clk) disable iff (!rst_i)
    wr_set |=> ((mask_q & $past(reg_wdata[NIRQ-1:0])) == $past(reg_wdata[NIRQ-1:0])));
  a_r9_clear_ones: assert property (@(posedge clk) disable iff (!rst_i)
    wr_clr |=> ((mask_q & $past(reg_wdata[NIRQ-1:0])) == '0));
  a_r11_drop_enable: assert property (@(posedge clk) disable iff (!rst_i)
    mf_event |=> (!en_q && mf_q));
  a_r10_start_gated: assert property (@(posedge clk) disable iff (!rst_i)
    eng_started |-> (en_q && msel_q && go_q));
  a_r3_go_self_clears: assert property (@(posedge clk) disable iff (!rst_i)
    (eng_started && !wr_cfg) |=> !go_q);
endmodule

// File: tb/spim_ctrl_bench.sv
module spim_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, sclk, mosi, cs_n;
  logic        miso_b = 1'b0;
  logic        ss_in_n = 1'b1;

  int checks = 0, fails = 0;
  logic cpol_b = 1'b0, cpha_b = 1'b0;

  spim_ctrl u_spim_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_sel(sel), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq), .sclk(sclk), .mosi(mosi),
    .miso(miso_b), .cs_n(cs_n), .ss_in_n(ss_in_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] sbyte(input int s, input int k);
    return 8'((k * 29 + s * 53 + 7) & 255);
  endfunction
  function automatic logic sbit(input int s, input int p);
    logic [7:0] b;
    b = sbyte(s, p / 8);
    return b[7 - (p % 8)];
  endfunction

  // slave model: captures MOSI, serves MISO
  int ncap = 0, nbits = 0, bursts = 0, sptr = 0;
  logic [7:0] cur = '0;
  logic [7:0] cap [0:63];
  logic cs_prev = 1'b1, fall_sclk = 1'b0, lead;
  always @(sclk or cs_n) begin
    if (cs_n !== cs_prev) begin
      cs_prev = cs_n;
      if (!cs_n) begin
        bursts = bursts + 1;
        nbits = 0;
        fall_sclk = sclk;
        if (!cpha_b) begin miso_b = sbit(bursts, 0); sptr = 1; end
        else sptr = 0;
      end
    end else if (!cs_n) begin
      lead = (sclk != cpol_b);
      if (lead ^ cpha_b) begin
        cur = {cur[6:0], mosi};
        nbits = nbits + 1;
        if (nbits % 8 == 0) begin cap[ncap % 64] = cur; ncap = ncap + 1; end
      end else begin
        miso_b = sbit(bursts, sptr);
        sptr = sptr + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 1'b0;
  endtask

  function automatic logic [15:0] cfgw(input logic pol, input logic pha, input logic [1:0] wc,
                                       input logic [2:0] dv, input logic ms, input logic go);
    return {7'd0, go, ms, dv, wc, pha, pol};
  endfunction

  task automatic wait_cs(input logic lvl);
    while (cs_n !== lvl) @(negedge clk);
  endtask

  logic [15:0] d;
  int base, b0, t0, t1;

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rreg(3'd0, d); chk(d == 16'h0, "R3 reset cfg", d, 0);
    rreg(3'd4, d); chk(d == 16'h4, "R8 reset status", d, 4);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R6 reset pins", {cs_n, sclk}, 2);
    chk(irq == 1'b0, "R8 reset irq", irq, 0);
    wreg(3'd1, 16'h1);

    // R1 divisor sweep
    for (int c = 0; c < 8; c++) begin
      cpol_b = 0; cpha_b = 0;
      wreg(3'd0, cfgw(0, 0, 2'b00, 3'(c), 1, 0));
      wreg(3'd2, 16'h5A);
      wreg(3'd0, cfgw(0, 0, 2'b00, 3'(c), 1, 1));
      @(posedge sclk); t0 = $time;
      @(posedge sclk); t1 = $time;
      chk((t1 - t0) / CLK_PERIOD == (2 << c), "R1 sclk period", (t1 - t0) / CLK_PERIOD, 2 << c);
      wait_cs(1'b1);
      rreg(3'd3, d);
    end

    // R2 R4 R6 all four modes, three back-to-back bytes
    for (int m = 0; m < 4; m++) begin
      cpol_b = m[1]; cpha_b = m[0];
      wreg(3'd0, cfgw(m[1], m[0], 2'b00, 3'd1, 1, 0));
      base = ncap; b0 = bursts;
      for (int i = 0; i < 3; i++) wreg(3'd2, 16'(8'(m * 16 + i * 34 + 49)));
      wreg(3'd0, cfgw(m[1], m[0], 2'b00, 3'd1, 1, 1));
      wait_cs(1'b0); wait_cs(1'b1);
      repeat (2) @(negedge clk);
      chk(bursts == b0 + 1, "R6 single cs window", bursts - b0, 1);
      chk(fall_sclk == m[1], "R6 sclk idle at cs fall", fall_sclk, m[1]);
      chk(sclk == m[1], "R6 sclk idle after burst", sclk, m[1]);
      chk(ncap - base == 3, "R2 byte count", ncap - base, 3);
      for (int i = 0; i < 3; i++)
        chk(cap[(base + i) % 64] == 8'(m * 16 + i * 34 + 49), "R2 mosi byte",
            cap[(base + i) % 64], 8'(m * 16 + i * 34 + 49));
      for (int i = 0; i < 3; i++) begin
        rreg(3'd3, d);
        chk(d == 16'(sbyte(b0 + 1, i)), "R4 rx order", d, sbyte(b0 + 1, i));
      end
      rreg(3'd4, d); chk(d[3] == 1'b0, "R4 rx drained", d[3], 0);
    end
    rreg(3'd3, d); chk(d == 16'h0, "R4 empty read zero", d, 0);

    // R5 16-bit frames with odd byte count
    cpol_b = 0; cpha_b = 1;
    wreg(3'd0, cfgw(0, 1, 2'b01, 3'd0, 1, 0));
    base = ncap; b0 = bursts;
    for (int i = 0; i < 3; i++) wreg(3'd2, 16'(8'(8'hC1 + i)));
    wreg(3'd0, cfgw(0, 1, 2'b01, 3'd0, 1, 1));
    wait_cs(1'b0); wait_cs(1'b1);
    chk(ncap - base == 4, "R5 padded frame count", ncap - base, 4);
    chk(cap[(base + 2) % 64] == 8'hC3, "R5 high byte", cap[(base + 2) % 64], 8'hC3);
    chk(cap[(base + 3) % 64] == 8'h00, "R5 pad byte", cap[(base + 3) % 64], 0);
    for (int i = 0; i < 4; i++) begin
      rreg(3'd3, d);
      chk(d == 16'(sbyte(b0 + 1, i)), "R5 rx both halves", d, sbyte(b0 + 1, i));
    end

    // R3 manual start
    cpol_b = 0; cpha_b = 0;
    wreg(3'd0, cfgw(0, 0, 2'b00, 3'd0, 1, 0));
    b0 = bursts;
    wreg(3'd2, 16'h11); wreg(3'd2, 16'h22);
    repeat (40) @(negedge clk);
    chk(bursts == b0 && cs_n == 1'b1, "R3 no start on data write", bursts - b0, 0);
    wreg(3'd0, cfgw(0, 0, 2'b00, 3'd0, 1, 1));
    wait_cs(1'b0);
    rreg(3'd0, d); chk(d[8] == 1'b0, "R3 go self clears", d[8], 0);
    wait_cs(1'b1);
    rreg(3'd3, d); rreg(3'd3, d);

    // R10 enable gate with pending go
    wreg(3'd1, 16'h0);
    b0 = bursts;
    wreg(3'd2, 16'h33);
    wreg(3'd0, cfgw(0, 0, 2'b00, 3'd0, 1, 1));
    wreg(3'd0, cfgw(0, 0, 2'b00, 3'd0, 1, 0));
    repeat (40) @(negedge clk);
    chk(bursts == b0, "R10 no burst while disabled", bursts - b0, 0);
    rreg(3'd0, d); chk(d[8] == 1'b1, "R10 go stays pending", d[8], 1);
    wreg(3'd1, 16'h1);
    wait_cs(1'b0); wait_cs(1'b1);
    chk(bursts == b0 + 1, "R10 pending burst runs", bursts - b0, 1);
    rreg(3'd3, d);

    // R7 R8 R9 full queue and mask
    base = ncap; b0 = bursts;
    for (int i = 0; i < 9; i++) wreg(3'd2, 16'(8'hA0 + i));
    rreg(3'd4, d); chk(d == 16'h2, "R7 full status", d, 2);
    wreg(3'd5, 16'h2);
    #1 chk(irq == 1'b1, "R8 irq on full", irq, 1);
    rreg(3'd5, d); chk(d == 16'h2, "R9 set readback", d, 2);
    wreg(3'd5, 16'h8); wreg(3'd6, 16'h2);
    rreg(3'd6, d); chk(d == 16'h8, "R9 clear readback", d, 8);
    #1 chk(irq == 1'b0, "R8 irq masked", irq, 0);
    wreg(3'd0, cfgw(0, 0, 2'b00, 3'd0, 1, 1));
    wait_cs(1'b0); wait_cs(1'b1);
    chk(ncap - base == 8, "R7 ninth write dropped", ncap - base, 8);
    chk(cap[(base + 7) % 64] == 8'hA7, "R7 last kept byte", cap[(base + 7) % 64], 8'hA7);
    #1 chk(irq == 1'b1, "R8 irq rx not empty", irq, 1);
    for (int i = 0; i < 8; i++) begin
      rreg(3'd3, d);
      chk(d == 16'(sbyte(b0 + 1, i)), "R7 rx depth", d, sbyte(b0 + 1, i));
    end
    rreg(3'd3, d); chk(d == 16'h0, "R4 empty after drain", d, 0);
    wreg(3'd6, 16'hF);
    rreg(3'd5, d); chk(d == 16'h0, "R9 all cleared", d, 0);

    // R11 mode fail ignored without master select
    wreg(3'd0, cfgw(0, 0, 2'b00, 3'd0, 0, 0));
    @(negedge clk); ss_in_n = 1'b0;
    repeat (3) @(negedge clk); ss_in_n = 1'b1;
    rreg(3'd1, d); chk(d == 16'h1, "R11 no fail as non-master", d, 1);
    rreg(3'd4, d); chk(d == 16'h4, "R11 flag clear as non-master", d, 4);

    // R11 mode fail while idle master
    wreg(3'd0, cfgw(0, 0, 2'b00, 3'd0, 1, 0));
    wreg(3'd5, 16'h1);
    @(negedge clk); ss_in_n = 1'b0;
    repeat (3) @(negedge clk); ss_in_n = 1'b1;
    rreg(3'd1, d); chk(d == 16'h0, "R11 enable dropped", d, 0);
    rreg(3'd4, d); chk(d == 16'h5, "R11 flag set", d, 5);
    #1 chk(irq == 1'b1, "R11 irq", irq, 1);
    wreg(3'd4, 16'h1);
    rreg(3'd4, d); chk(d == 16'h4, "R11 flag w1c", d, 4);

    // R11 abort mid burst
    wreg(3'd1, 16'h1);
    for (int i = 0; i < 3; i++) wreg(3'd2, 16'h77);
    wreg(3'd0, cfgw(0, 0, 2'b00, 3'd3, 1, 1));
    wait_cs(1'b0);
    repeat (20) @(negedge clk);
    ss_in_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(cs_n == 1'b1, "R11 abort releases cs", cs_n, 1);
    ss_in_n = 1'b1;
    rreg(3'd1, d); chk(d == 16'h0, "R11 abort drops enable", d, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule